// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a small data cache placed between a processor load/store port and a slower line-oriented memory. The processor side uses a valid/ready handshake. Each request carries a direction, a byte address, a write word and per-byte enables. A response comes back one cycle after acceptance whenever the addressed line is resident. Each cache line has a tag and a three-valued line state held together in one tag store: empty, present-unmodified or present-modified. The data words sit in a separate data store.

A miss stalls the processor until the line is in place. The controller latches the request and leaves `IDLE`. If the resident line is modified, it first streams that line out beat by beat (`WRITEBACK`). An empty or unmodified victim is simply overwritten. The controller then asks the memory for the new line (`REQUEST`) and collects its beats into a fill buffer (`REFILL`). In one further cycle (`RESPOND`) it writes the data and tag stores, merges the store bytes of a write miss, and returns the response. Stores that miss are allocated exactly like loads.

The named transitions are:
- IDLE→IDLE on a hit, or when no request is present.
- IDLE→WRITEBACK on a miss over a modified line.
- IDLE→REQUEST on a miss over an empty or unmodified line.
- WRITEBACK→REQUEST when the last victim beat is accepted.
- REQUEST→REFILL on the memory acknowledge.
- REFILL→RESPOND when the last refill beat arrives.
- RESPOND→IDLE unconditionally.

Top module: `cache_wb_ctrl`

## Requirements
- R1: After reset every line is empty: req_ready is 1, resp_valid is 0, no memory transfer is active, and the first access to any line is a miss.
- R2: The byte address splits as word select addr[3:2], set addr[6:4] and tag addr[31:7] (16-byte lines, 8 sets). A hit requires the set's stored tag to match and its state to be non-empty.
- R3: A read hit raises resp_valid in the cycle after acceptance, carrying the addressed word, with no memory transfer.
- R4: A write hit updates only the byte lanes whose req_be bit is set (bit i covers data bits 8i+7..8i). It marks the line modified, causes no memory transfer and responds in the cycle after acceptance.
- R5: A miss whose victim is empty or unmodified issues no write-back beat.
- R6: A miss whose victim is modified sends four write-back beats before the refill request. The beats go to the victim's tag and set, word 0 to word 3 in ascending address order, and carry the line's current contents.
- R7: Every miss issues one refill request with a line-aligned address, held stable until acknowledged. The four returning beats fill words 0 to 3 in arrival order, and the requested word is returned for a read.
- R8: A write miss fetches the whole line, then merges the enabled store bytes into it. The line is left modified, so a later eviction writes the merged data back.
- R9: req_ready is 0 from the cycle after a miss is accepted until its response, so no second request is taken during a miss.
- R10: The miss sequence runs in the fixed order IDLE, optional WRITEBACK, REQUEST, REFILL, RESPOND, IDLE. A miss response therefore comes no earlier than 7 cycles after acceptance, or 11 cycles when a write-back is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can take a request (IDLE) |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| resp_valid | output | 1 | Response present for one cycle |
| resp_rdata | output | 32 | Load data |
| mem_wb_valid | output | 1 | Write-back beat present |
| mem_wb_ready | input | 1 | Memory takes the write-back beat |
| mem_wb_addr | output | 32 | Byte address of the write-back word |
| mem_wb_data | output | 32 | Write-back word |
| mem_rd_req | output | 1 | Line fetch request |
| mem_rd_ack | input | 1 | Memory accepts the fetch request |
| mem_rd_addr | output | 32 | Line-aligned fetch address |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | 32 | Refill word |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the memory port is quiet while a request can be accepted, that responses only appear in IDLE, that each accepted request leads either to a response or to a stall, and that write-back beats and refill requests never overlap and hold steady under back-pressure. It also checks that the fetch address is line-aligned and that a finished write-back is always followed by the refill request. Only the bench sweeps can show that the data is correct: merged bytes after hits and write misses, the correct victim address order, modified data surviving an eviction and refill, and the hit/miss pattern produced by tag conflicts across every set.

// File: rtl/cache_wb_pkg.sv
package cache_wb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WRITEBACK = 3'd1,
        ST_REQUEST   = 3'd2,
        ST_REFILL    = 3'd3,
        ST_RESPOND   = 3'd4
    } ctl_state_e;

    typedef enum logic [1:0] {
        LN_INVALID = 2'b00,
        LN_CLEAN   = 2'b01,
        LN_DIRTY   = 2'b11
    } line_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_wb_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output line_state_e       rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  line_state_e       wr_state
);

    logic [TAG_W-1:0] tag_q [SETS];
    line_state_e      st_q  [SETS];

    // Tag and line state share one entry per set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                st_q[s]  <= LN_INVALID;
            end
        end else if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            st_q[wr_idx]  <= wr_state;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int SETS   = 8,
    parameter int IDX_W  = 3,
    parameter int WORDS  = 4,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WORDS*DATA_W-1:0] rd_line,
    input  logic                    word_we,
    input  logic [IDX_W-1:0]        word_idx,
    input  logic [WSEL_W-1:0]       word_sel,
    input  logic [DATA_W/8-1:0]     word_be,
    input  logic [DATA_W-1:0]       word_data,
    input  logic                    line_we,
    input  logic [IDX_W-1:0]        line_idx,
    input  logic [WORDS*DATA_W-1:0] line_data
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem_q [SETS][WORDS];

    // A whole-line fill takes precedence over a byte-lane store.
    always_ff @(posedge clk) begin
        if (line_we) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[line_idx][w] <= line_data[w*DATA_W +: DATA_W];
            end
        end else if (word_we) begin
            for (int b = 0; b < LANES; b++) begin
                if (word_be[b]) begin
                    mem_q[word_idx][word_sel][b*8 +: 8] <= word_data[b*8 +: 8];
                end
            end
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_rd
        assign rd_line[w*DATA_W +: DATA_W] = mem_q[rd_idx][w];
    end

endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
    import cache_wb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                resp_valid,
    output logic [DATA_W-1:0]   resp_rdata,
    output logic                mem_wb_valid,
    input  logic                mem_wb_ready,
    output logic [ADDR_W-1:0]   mem_wb_addr,
    output logic [DATA_W-1:0]   mem_wb_data,
    output logic                mem_rd_req,
    input  logic                mem_rd_ack,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [DATA_W-1:0]   mem_rd_data
);

    localparam int BYTES_W = DATA_W / 8;
    localparam int WORDS   = LINE_BYTES / BYTES_W;
    localparam int BOFF_W  = $clog2(BYTES_W);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int OFF_W   = BOFF_W + WSEL_W;
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W  = WORDS * DATA_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    ctl_state_e state_q, state_d;

    // Latched miss request
    logic                rq_we;
    logic [ADDR_W-1:0]   rq_addr;
    logic [DATA_W-1:0]   rq_wdata;
    logic [BYTES_W-1:0]  rq_be;

    logic [WSEL_W-1:0]   beat_q;
    logic [LINE_W-1:0]   fill_q;
    logic                resp_valid_q;
    logic [DATA_W-1:0]   resp_rdata_q;

    // Address fields
    logic [TAG_W-1:0]  req_tag, rq_tag;
    logic [IDX_W-1:0]  req_idx, rq_idx, lk_idx;
    logic [WSEL_W-1:0] req_word, rq_word;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_word = req_addr[BOFF_W +: WSEL_W];
    assign rq_tag   = rq_addr[ADDR_W-1 -: TAG_W];
    assign rq_idx   = rq_addr[OFF_W +: IDX_W];
    assign rq_word  = rq_addr[BOFF_W +: WSEL_W];
    assign lk_idx   = (state_q == ST_IDLE) ? req_idx : rq_idx;

    // Store interfaces
    logic [TAG_W-1:0] ts_tag;
    line_state_e      ts_state;
    logic             tag_we;
    logic [TAG_W-1:0] tag_wr_tag;
    line_state_e      tag_wr_state;
    logic [LINE_W-1:0] ds_line;
    logic             word_we, line_we;
    logic [LINE_W-1:0] fill_line;
    logic [DATA_W-1:0] fill_word, merged_word;

    logic hit, accept;
    assign hit    = (ts_state != LN_INVALID) && (ts_tag == req_tag);
    assign accept = req_valid && (state_q == ST_IDLE);

    cache_tag_store #(
        .SETS (SETS),
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_tag  (ts_tag),
        .rd_state(ts_state),
        .wr_en   (tag_we),
        .wr_idx  (lk_idx),
        .wr_tag  (tag_wr_tag),
        .wr_state(tag_wr_state)
    );

    cache_data_store #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .WORDS (WORDS),
        .WSEL_W(WSEL_W),
        .DATA_W(DATA_W)
    ) u_data (
        .clk      (clk),
        .rd_idx   (lk_idx),
        .rd_line  (ds_line),
        .word_we  (word_we),
        .word_idx (req_idx),
        .word_sel (req_word),
        .word_be  (req_be),
        .word_data(req_wdata),
        .line_we  (line_we),
        .line_idx (rq_idx),
        .line_data(fill_line)
    );

    // Write-miss merge of the store bytes into the fetched word
    assign fill_word = fill_q[rq_word*DATA_W +: DATA_W];

    for (genvar b = 0; b < BYTES_W; b++) begin : g_merge
        assign merged_word[b*8 +: 8] = (rq_we && rq_be[b]) ? rq_wdata[b*8 +: 8]
                                                           : fill_word[b*8 +: 8];
    end

    always_comb begin
        fill_line = fill_q;
        fill_line[rq_word*DATA_W +: DATA_W] = merged_word;
    end

    // Memory-side data paths
    assign mem_wb_addr = {ts_tag, rq_idx, beat_q, {BOFF_W{1'b0}}};
    assign mem_wb_data = ds_line[beat_q*DATA_W +: DATA_W];
    assign mem_rd_addr = {rq_tag, rq_idx, {OFF_W{1'b0}}};
    assign resp_valid  = resp_valid_q;
    assign resp_rdata  = resp_rdata_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d      = state_q;
        req_ready    = 1'b0;
        mem_wb_valid = 1'b0;
        mem_rd_req   = 1'b0;
        tag_we       = 1'b0;
        tag_wr_tag   = rq_tag;
        tag_wr_state = LN_CLEAN;
        word_we      = 1'b0;
        line_we      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (accept) begin
                    if (hit) begin
                        if (req_we) begin
                            word_we      = 1'b1;
                            tag_we       = 1'b1;
                            tag_wr_tag   = req_tag;
                            tag_wr_state = LN_DIRTY;
                        end
                    end else if (ts_state == LN_DIRTY) begin
                        state_d = ST_WRITEBACK;
                    end else begin
                        state_d = ST_REQUEST;
                    end
                end
            end
            ST_WRITEBACK: begin
                mem_wb_valid = 1'b1;
                if (mem_wb_ready && beat_q == LAST_BEAT) state_d = ST_REQUEST;
            end
            ST_REQUEST: begin
                mem_rd_req = 1'b1;
                if (mem_rd_ack) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (mem_rd_valid && beat_q == LAST_BEAT) state_d = ST_RESPOND;
            end
            ST_RESPOND: begin
                line_we      = 1'b1;
                tag_we       = 1'b1;
                tag_wr_state = rq_we ? LN_DIRTY : LN_CLEAN;
                state_d      = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request latch, beat counter, fill buffer and response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we        <= 1'b0;
            rq_addr      <= '0;
            rq_wdata     <= '0;
            rq_be        <= '0;
            beat_q       <= '0;
            fill_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            if (accept) begin
                if (hit) begin
                    resp_valid_q <= 1'b1;
                    resp_rdata_q <= ds_line[req_word*DATA_W +: DATA_W];
                end else begin
                    rq_we    <= req_we;
                    rq_addr  <= req_addr;
                    rq_wdata <= req_wdata;
                    rq_be    <= req_be;
                    beat_q   <= '0;
                end
            end
            if (state_q == ST_WRITEBACK && mem_wb_ready) begin
                beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_REFILL && mem_rd_valid) begin
                fill_q[beat_q*DATA_W +: DATA_W] <= mem_rd_data;
                beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_RESPOND) begin
                resp_valid_q <= 1'b1;
                resp_rdata_q <= merged_word;
            end
        end
    end

endmodule

// File: rtl/cache_wb_ctrl_chk.sv
module cache_wb_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_wb_valid,
    input logic              mem_wb_ready,
    input logic [ADDR_W-1:0] mem_wb_addr,
    input logic              mem_rd_req,
    input logic              mem_rd_ack,
    input logic [ADDR_W-1:0] mem_rd_addr
);

    // R9: while a request can be taken, the memory port is idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_wb_valid && !mem_rd_req));

    // R3: responses appear only with the controller back in IDLE
    p_resp_in_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R10: an accepted request either answers next cycle or stalls
    p_accept_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (resp_valid || !req_ready));

    // R6: write-back beats and the refill request never overlap
    p_wb_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb_valid |-> !mem_rd_req);

    // R6: a stalled write-back beat keeps its address
    p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wb_valid && !mem_wb_ready) |=> (mem_wb_valid && $stable(mem_wb_addr)));

    // R7: an unacknowledged fetch request stays up and stable
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R7: fetch addresses are line aligned
    p_rd_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

    // R10: the end of a write-back leads straight into the fetch request
    p_wb_then_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wb_valid) |-> mem_rd_req);

endmodule

bind cache_wb_ctrl cache_wb_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .mem_wb_valid(mem_wb_valid),
    .mem_wb_ready(mem_wb_ready),
    .mem_wb_addr (mem_wb_addr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/cache_wb_ctrl_tb.sv
module cache_wb_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_wb_valid;
    logic        mem_wb_ready;
    logic [31:0] mem_wb_addr;
    logic [31:0] mem_wb_data;
    logic        mem_rd_req;
    logic        mem_rd_ack;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;

    always #10 clk = ~clk;

    cache_wb_ctrl u_dut (.*);

    int checks = 0;
    int fails  = 0;

    // Backing memory model: 256 words, alternating-cycle back-pressure
    logic [31:0] bmem [256];
    logic [31:0] refm [256];
    logic        tog;
    logic        rd_pend;
    logic [7:0]  rd_base;
    logic [1:0]  rd_beat;
    int          wb_total;
    int          rd_total;
    logic [31:0] wb_log [64];
    int          wb_rdl [64];

    function automatic logic [31:0] seed_word(int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0101);
    endfunction

    assign mem_wb_ready = tog;
    assign mem_rd_ack   = mem_rd_req && !tog;
    assign mem_rd_valid = rd_pend && tog;
    assign mem_rd_data  = bmem[rd_base + 8'(rd_beat)];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= seed_word(i);
            tog      <= 1'b0;
            rd_pend  <= 1'b0;
            rd_base  <= '0;
            rd_beat  <= '0;
            wb_total <= 0;
            rd_total <= 0;
        end else begin
            tog <= ~tog;
            if (mem_wb_valid && mem_wb_ready) begin
                bmem[mem_wb_addr[9:2]] <= mem_wb_data;
                wb_log[wb_total % 64]  <= mem_wb_addr;
                wb_rdl[wb_total % 64]  <= rd_total;
                wb_total <= wb_total + 1;
            end
            if (mem_rd_req && mem_rd_ack) begin
                rd_pend  <= 1'b1;
                rd_base  <= mem_rd_addr[9:2];
                rd_beat  <= '0;
                rd_total <= rd_total + 1;
            end else if (mem_rd_valid) begin
                rd_beat <= rd_beat + 2'd1;
                if (rd_beat == 2'd3) rd_pend <= 1'b0;
            end
        end
    end

    // Expected cache contents, derived from the requirements
    logic        mval   [8];
    logic        mdirty [8];
    logic [24:0] mtag   [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [3:0] be);
        logic [2:0]  ix;
        logic [24:0] tg;
        logic        exp_hit, exp_wb;
        logic [24:0] vtag;
        logic [31:0] expw;
        int wb0, rd0, cyc;
        ix      = addr[6:4];
        tg      = addr[31:7];
        exp_hit = mval[ix] && (mtag[ix] == tg);
        exp_wb  = !exp_hit && mval[ix] && mdirty[ix];
        vtag    = mtag[ix];
        wb0     = wb_total;
        rd0     = rd_total;
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = addr;
        req_wdata = wd;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        chk(req_ready == exp_hit, exp_hit ? "R3" : "R9", "ready after accept",
            32'(req_ready), 32'(exp_hit));
        while (!resp_valid && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        chk(resp_valid, "R10", "response arrives", 32'(resp_valid), 32'd1);
        if (exp_hit)
            chk(cyc == 1, we ? "R4" : "R3", "hit latency", 32'(cyc), 32'd1);
        else
            chk(cyc >= (exp_wb ? 11 : 7), "R10", "miss latency floor",
                32'(cyc), exp_wb ? 32'd11 : 32'd7);
        if (!we)
            chk(resp_rdata == refm[addr[9:2]], exp_hit ? "R3" : "R7", "load data",
                resp_rdata, refm[addr[9:2]]);
        chk((rd_total - rd0) == (exp_hit ? 0 : 1), exp_hit ? "R4" : "R7",
            "fetch request count", 32'(rd_total - rd0), exp_hit ? 32'd0 : 32'd1);
        chk((wb_total - wb0) == (exp_wb ? 4 : 0), exp_wb ? "R6" : "R5",
            "write-back beat count", 32'(wb_total - wb0), exp_wb ? 32'd4 : 32'd0);
        if (exp_wb && (wb_total - wb0) == 4) begin
            for (int k = 0; k < 4; k++) begin
                expw = {vtag, ix, 2'(k), 2'b00};
                chk(wb_log[(wb0 + k) % 64] == expw, "R6", "write-back address",
                    wb_log[(wb0 + k) % 64], expw);
                chk(wb_rdl[(wb0 + k) % 64] == rd0, "R6", "write-back before fetch",
                    32'(wb_rdl[(wb0 + k) % 64]), 32'(rd0));
            end
        end
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) refm[addr[9:2]][b*8 +: 8] = wd[b*8 +: 8];
        end
        mval[ix] = 1'b1;
        mtag[ix] = tg;
        if (we)            mdirty[ix] = 1'b1;
        else if (!exp_hit) mdirty[ix] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) refm[i] = seed_word(i);
        for (int s = 0; s < 8; s++) begin
            mval[s] = 1'b0; mdirty[s] = 1'b0; mtag[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R1", "no response after reset", 32'(resp_valid), 32'd0);
        chk(!mem_wb_valid && !mem_rd_req, "R1", "memory idle after reset",
            32'({mem_wb_valid, mem_rd_req}), 32'd0);

        // R1 R2 R5 R7: load sweep over four tags in every set
        for (int a = 0; a < 512; a += 4) access(1'b0, 32'(a), 32'd0, 4'h0);
        // R4 R6 R8: store sweep with rotating byte enables over eight tags
        for (int a = 0; a < 1024; a += 4)
            access(1'b1, 32'(a), (32'(a) * 32'h0001_0001) ^ 32'h3C3C_0000,
                   4'(((a >> 2) % 15) + 1));
        // R6 R7: reload everything; modified lines must round-trip through memory
        for (int a = 0; a < 1024; a += 4) access(1'b0, 32'(a), 32'd0, 4'h0);
        // R8: write miss over a clean line, then load the merged word
        access(1'b1, 32'h0000_0010, 32'hDEAD_BEEF, 4'b0010);
        access(1'b0, 32'h0000_0010, 32'd0, 4'h0);
        // R4: partial write hit then load
        access(1'b1, 32'h0000_0014, 32'h1122_3344, 4'b1001);
        access(1'b0, 32'h0000_0014, 32'd0, 4'h0);
        // R2 R6: same set, other tag, evicts the modified line
        access(1'b0, 32'h0000_0090, 32'd0, 4'h0);
        access(1'b0, 32'h0000_0014, 32'd0, 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule